// File: doc/BRIEF.md
# Processor Mode and Bank Register Controller

This block holds the mode-dependent architectural state of an 8/16-bit compatible CPU core. That state is the emulation flag, the accumulator-width (M) and index-width (X) status bits, the high bytes of the stack pointer and of both index registers, and the program and data bank registers. Decode, the ALU and the bus sequencer sit outside the block. They drive it through single-cycle command strobes: interrupt entry, status modify and mode switch. A plain register-write port loads the bytes the block owns.

A switch into emulation forces the width bits and the high register bytes to fixed values. While the core is in emulation, the width bits cannot be cleared. Interrupt entry clears the bank registers in a mode-dependent way. In native mode it also hands the sequencer a one-cycle push request together with the old program bank. The block presents the width bits as a 2-bit status output. A valid flag drops for the one cycle that follows any status update.

Top module: `cpu_mode_ctrl`

## Requirements
- R1: After reset: emulation flag 1, M=1, X=1, stack high byte 0x01, index high bytes 0x00, both banks 0x00, push request 0, saved bank 0x00, MX valid 1.
- R2: A mode switch into emulation (`mode_req` with `mode_to_emul`=1) sets M and X to 1, stack high byte to 0x01 and both index high bytes to 0x00, and leaves both bank registers unchanged.
- R3: A mode switch into native (`mode_to_emul`=0) clears only the emulation flag. M, X, the high bytes and the banks keep their values.
- R4: While in emulation, M and X read 1 at all times, and status commands of any kind leave them at 1.
- R5: In native mode a status command changes the bits selected by `stat_data` bit 5 (M) and bit 4 (X). `stat_kind` 00 clears the selected bits and 01 sets them. 10 or 11 loads M from bit 5 and X from bit 4. The other bits of `stat_data` have no effect.
- R6: A native-mode interrupt entry clears the program bank and leaves the data bank unchanged. The cycle after the event, it raises `push_pb` for exactly one cycle, with `saved_pb` equal to the program bank held before the event.
- R7: An emulation-mode interrupt entry clears both the program and data bank registers and does not raise `push_pb`.
- R8: `mx_out` equals {M, X} in every cycle. `mx_valid` is 0 for exactly the one cycle after each accepted status command and 1 otherwise.
- R9: When commands coincide, interrupt entry wins over a status command, and a status command wins over a mode switch. Only the winner takes effect in that cycle.
- R10: A register write (`wr_sel` 0 stack high, 1 X high, 2 Y high, 3 program bank, 4 data bank) is applied only when no command strobe is active in the same cycle. In emulation, writes to the three high bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt, break or trap entry strobe |
| stat_req | input | 1 | Status modify strobe |
| stat_kind | input | 2 | 00 clear bits, 01 set bits, 1x load byte |
| stat_data | input | 8 | Mask or status byte; bit 5 M, bit 4 X |
| mode_req | input | 1 | Mode switch strobe |
| mode_to_emul | input | 1 | Target mode: 1 emulation, 0 native |
| wr_req | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector |
| wr_data | input | W | Register write value |
| emul_flag | output | 1 | Emulation flag |
| m_flag | output | 1 | Accumulator width bit |
| x_flag | output | 1 | Index width bit |
| mx_out | output | 2 | {M, X} status output |
| mx_valid | output | 1 | MX output valid |
| sp_hi | output | W | Stack pointer high byte |
| x_hi | output | W | X index high byte |
| y_hi | output | W | Y index high byte |
| pbank | output | W | Program bank register |
| dbank | output | W | Data bank register |
| push_pb | output | 1 | Request to push old program bank |
| saved_pb | output | W | Program bank value before the last interrupt |

## Verification
The assertions assume that every command arrives as a strobe sampled at one clock edge. They also assume that any overlap of strobes is resolved only by the block's own priority, with no outside guarantee that commands are exclusive. The bench drives each strobe for exactly one clock, setting inputs on the falling edge and returning them to idle at the next falling edge. It deliberately stacks interrupt, status, mode and write strobes in the same cycle so that the priority chain is exercised inside those assumptions.

// File: rtl/mode_pkg.sv
package mode_pkg;
  // Status command kinds
  localparam logic [1:0] STK_CLR = 2'b00;
  localparam logic [1:0] STK_SET = 2'b01;

  // Bit positions of the width bits inside the status byte
  localparam int M_BIT = 5;
  localparam int X_BIT = 4;

  // Register selector codes
  localparam logic [2:0] SEL_SPH = 3'd0;
  localparam logic [2:0] SEL_XH  = 3'd1;
  localparam logic [2:0] SEL_YH  = 3'd2;
  localparam logic [2:0] SEL_PB  = 3'd3;
  localparam logic [2:0] SEL_DB  = 3'd4;

  // New {M, X} after a status command in native mode
  function automatic logic [1:0] next_mx(input logic [1:0] kind,
                                         input logic [7:0] data,
                                         input logic [1:0] cur);
    logic [1:0] sel;
    sel = {data[M_BIT], data[X_BIT]};
    if (kind == STK_CLR)      return cur & ~sel;
    else if (kind == STK_SET) return cur | sel;
    else                      return sel;
  endfunction
endpackage

// File: rtl/mx_unit.sv
module mx_unit
  import mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_fire,
  input  logic [1:0] stat_kind,
  input  logic [7:0] stat_data,
  input  logic       sw_fire,
  input  logic       mode_to_emul,
  output logic       emul_flag,
  output logic       m_flag,
  output logic       x_flag,
  output logic       mx_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emul_flag <= 1'b1;
      m_flag    <= 1'b1;
      x_flag    <= 1'b1;
      mx_valid  <= 1'b1;
    end else begin
      mx_valid <= ~stat_fire;
      if (stat_fire) begin
        if (!emul_flag)
          {m_flag, x_flag} <= next_mx(stat_kind, stat_data, {m_flag, x_flag});
      end else if (sw_fire) begin
        emul_flag <= mode_to_emul;
        if (mode_to_emul) begin
          m_flag <= 1'b1;
          x_flag <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hireg_unit.sv
module hireg_unit
  import mode_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emul_enter,
  input  logic         emul_flag,
  input  logic         wr_fire,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] sp_hi,
  output logic [W-1:0] x_hi,
  output logic [W-1:0] y_hi
);
  localparam logic [W-1:0] SPH_EMUL = W'(1);

  wire hi_wr_ok = wr_fire && !emul_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_hi <= SPH_EMUL;
      x_hi  <= '0;
      y_hi  <= '0;
    end else if (emul_enter) begin
      sp_hi <= SPH_EMUL;
      x_hi  <= '0;
      y_hi  <= '0;
    end else if (hi_wr_ok) begin
      case (wr_sel)
        SEL_SPH: sp_hi <= wr_data;
        SEL_XH:  x_hi  <= wr_data;
        SEL_YH:  y_hi  <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bank_unit.sv
module bank_unit
  import mode_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_fire,
  input  logic         emul_flag,
  input  logic         wr_fire,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pbank,
  output logic [W-1:0] dbank,
  output logic         push_pb,
  output logic [W-1:0] saved_pb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pbank    <= '0;
      dbank    <= '0;
      push_pb  <= 1'b0;
      saved_pb <= '0;
    end else begin
      push_pb <= 1'b0;
      if (irq_fire) begin
        saved_pb <= pbank;
        pbank    <= '0;
        if (emul_flag) dbank <= '0;
        else           push_pb <= 1'b1;
      end else if (wr_fire) begin
        if (wr_sel == SEL_PB) pbank <= wr_data;
        if (wr_sel == SEL_DB) dbank <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cpu_mode_ctrl.sv
module cpu_mode_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_req,
  input  logic         stat_req,
  input  logic [1:0]   stat_kind,
  input  logic [7:0]   stat_data,
  input  logic         mode_req,
  input  logic         mode_to_emul,
  input  logic         wr_req,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         emul_flag,
  output logic         m_flag,
  output logic         x_flag,
  output logic [1:0]   mx_out,
  output logic         mx_valid,
  output logic [W-1:0] sp_hi,
  output logic [W-1:0] x_hi,
  output logic [W-1:0] y_hi,
  output logic [W-1:0] pbank,
  output logic [W-1:0] dbank,
  output logic         push_pb,
  output logic [W-1:0] saved_pb
);
  // Resolved events, brought out for the checker
  logic irq_fire, stat_fire, sw_fire, wr_fire, emul_enter;

  assign irq_fire   = irq_req;
  assign stat_fire  = stat_req && !irq_req;
  assign sw_fire    = mode_req && !stat_req && !irq_req;
  assign wr_fire    = wr_req && !mode_req && !stat_req && !irq_req;
  assign emul_enter = sw_fire && mode_to_emul;

  mx_unit u_mx (
    .clk, .rst_n, .stat_fire, .stat_kind, .stat_data,
    .sw_fire, .mode_to_emul, .emul_flag, .m_flag, .x_flag, .mx_valid
  );

  hireg_unit #(.W(W)) u_hi (
    .clk, .rst_n, .emul_enter, .emul_flag, .wr_fire, .wr_sel, .wr_data,
    .sp_hi, .x_hi, .y_hi
  );

  bank_unit #(.W(W)) u_bank (
    .clk, .rst_n, .irq_fire, .emul_flag, .wr_fire, .wr_sel, .wr_data,
    .pbank, .dbank, .push_pb, .saved_pb
  );

  assign mx_out = {m_flag, x_flag};
endmodule

// File: rtl/mode_ctrl_chk.sv
module mode_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_fire,
  input logic         stat_fire,
  input logic         sw_fire,
  input logic         mode_to_emul,
  input logic         emul_flag,
  input logic         m_flag,
  input logic         x_flag,
  input logic         mx_valid,
  input logic [W-1:0] sp_hi,
  input logic [W-1:0] x_hi,
  input logic [W-1:0] y_hi,
  input logic [W-1:0] pbank,
  input logic [W-1:0] dbank,
  input logic         push_pb,
  input logic [W-1:0] saved_pb
);
  // R2
  emul_hibytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emul_flag |-> (sp_hi == W'(1) && x_hi == '0 && y_hi == '0));

  // R4
  emul_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emul_flag |-> (m_flag && x_flag));

  // R3
  to_native_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fire && !mode_to_emul) |=> (!emul_flag && $stable(m_flag) && $stable(x_flag)
                                    && $stable(sp_hi) && $stable(pbank) && $stable(dbank)));

  // R6
  native_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fire && !emul_flag) |=> (push_pb && pbank == '0 && saved_pb == $past(pbank)
                                  && dbank == $past(dbank)));

  // R7
  emul_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fire && emul_flag) |=> (!push_pb && pbank == '0 && dbank == '0));

  // R6
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_pb |=> (!push_pb || $past(irq_fire)));

  // R8
  mx_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fire |=> !mx_valid);

  // R8
  mx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_fire |=> mx_valid);
endmodule

bind cpu_mode_ctrl mode_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/sim_cpu_mode_ctrl.sv
module sim_cpu_mode_ctrl;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 0, stat_req = 0, mode_req = 0, mode_to_emul = 0, wr_req = 0;
  logic [1:0] stat_kind = 0;
  logic [7:0] stat_data = 0;
  logic [2:0] wr_sel = 0;
  logic [W-1:0] wr_data = 0;
  logic emul_flag, m_flag, x_flag, mx_valid, push_pb;
  logic [1:0] mx_out;
  logic [W-1:0] sp_hi, x_hi, y_hi, pbank, dbank, saved_pb;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cpu_mode_ctrl #(.W(W)) u0 (.*);

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then return to idle; outputs sampled on return
  task automatic cyc(input logic irq, input logic st, input logic [1:0] kd, input logic [7:0] sd,
                     input logic md, input logic te, input logic wr, input logic [2:0] sel,
                     input logic [W-1:0] wd);
    @(negedge clk);
    irq_req = irq; stat_req = st; stat_kind = kd; stat_data = sd;
    mode_req = md; mode_to_emul = te; wr_req = wr; wr_sel = sel; wr_data = wd;
    @(negedge clk);
    irq_req = 0; stat_req = 0; mode_req = 0; wr_req = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 2'b00, 8'h00, 0, 0, 0, 3'd0, '0);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [W-1:0] d);
    cyc(0, 0, 2'b00, 8'h00, 0, 0, 1, sel, d);
  endtask

  task automatic stat(input logic [1:0] kd, input logic [7:0] d);
    cyc(0, 1, kd, d, 0, 0, 0, 3'd0, '0);
  endtask

  task automatic t_reset();
    chk("R1 emul", emul_flag, 1); chk("R1 m", m_flag, 1); chk("R1 x", x_flag, 1);
    chk("R1 sph", sp_hi, 8'h01); chk("R1 xh", x_hi, 0); chk("R1 yh", y_hi, 0);
    chk("R1 pb", pbank, 0); chk("R1 db", dbank, 0); chk("R1 push", push_pb, 0);
    chk("R1 saved", saved_pb, 0); chk("R1 valid", mx_valid, 1);
  endtask

  task automatic t_native_writes();
    wr(3'd0, 8'h55);
    chk("R10 emul sph write ignored", sp_hi, 8'h01);
    cyc(0, 0, 2'b00, 8'h00, 1, 0, 0, 3'd0, '0);
    chk("R3 emul cleared", emul_flag, 0); chk("R3 m kept", m_flag, 1);
    chk("R3 x kept", x_flag, 1); chk("R3 sph kept", sp_hi, 8'h01);
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h56); wr(3'd3, 8'h7A); wr(3'd4, 8'h5C);
    chk("R10 sph", sp_hi, 8'h12); chk("R10 xh", x_hi, 8'h34); chk("R10 yh", y_hi, 8'h56);
    chk("R10 pb", pbank, 8'h7A); chk("R10 db", dbank, 8'h5C);
  endtask

  task automatic t_stat_native();
    stat(2'b00, 8'h30);
    chk("R5 clr m", m_flag, 0); chk("R5 clr x", x_flag, 0);
    chk("R8 mx_out", mx_out, 2'b00); chk("R8 invalid", mx_valid, 0);
    idle();
    chk("R8 valid again", mx_valid, 1);
    stat(2'b01, 8'h20);
    chk("R5 set m only", mx_out, 2'b10);
    stat(2'b10, 8'h10);
    chk("R5 load", mx_out, 2'b01);
    stat(2'b00, 8'hCF);
    chk("R5 other bits ignored", mx_out, 2'b01);
    stat(2'b11, 8'hEF);
    chk("R5 load kind 11", mx_out, 2'b10);
    stat(2'b10, 8'h10);
    chk("R5 reload", mx_out, 2'b01);
  endtask

  task automatic t_irq_native();
    cyc(1, 0, 2'b00, 8'h00, 0, 0, 0, 3'd0, '0);
    chk("R6 pb clr", pbank, 0); chk("R6 db kept", dbank, 8'h5C);
    chk("R6 push", push_pb, 1); chk("R6 saved", saved_pb, 8'h7A);
    idle();
    chk("R6 push one cycle", push_pb, 0);
  endtask

  task automatic t_to_emul();
    wr(3'd3, 8'h22);
    cyc(0, 0, 2'b00, 8'h00, 1, 1, 0, 3'd0, '0);
    chk("R2 emul", emul_flag, 1); chk("R2 mx", mx_out, 2'b11);
    chk("R2 sph", sp_hi, 8'h01); chk("R2 xh", x_hi, 0); chk("R2 yh", y_hi, 0);
    chk("R2 pb kept", pbank, 8'h22); chk("R2 db kept", dbank, 8'h5C);
  endtask

  task automatic t_emul_stat();
    stat(2'b00, 8'h30);
    chk("R4 clr masked", mx_out, 2'b11); chk("R8 invalid emul", mx_valid, 0);
    stat(2'b10, 8'h00);
    chk("R4 load masked", mx_out, 2'b11);
    wr(3'd0, 8'h99); wr(3'd1, 8'h98);
    chk("R10 emul sph ignored", sp_hi, 8'h01); chk("R10 emul xh ignored", x_hi, 0);
    wr(3'd4, 8'h44);
    chk("R10 emul db write", dbank, 8'h44);
  endtask

  task automatic t_irq_emul();
    cyc(1, 0, 2'b00, 8'h00, 0, 0, 0, 3'd0, '0);
    chk("R7 pb clr", pbank, 0); chk("R7 db clr", dbank, 0); chk("R7 no push", push_pb, 0);
  endtask

  task automatic t_priority();
    cyc(0, 0, 2'b00, 8'h00, 1, 0, 0, 3'd0, '0);
    wr(3'd3, 8'h3C); wr(3'd4, 8'h61);
    cyc(1, 1, 2'b00, 8'h30, 1, 1, 1, 3'd3, 8'hAA);
    chk("R9 irq wins pb", pbank, 0); chk("R9 irq wins push", push_pb, 1);
    chk("R9 irq saved", saved_pb, 8'h3C); chk("R9 stat lost", mx_out, 2'b11);
    chk("R9 switch lost", emul_flag, 0); chk("R9 no invalid", mx_valid, 1);
    cyc(0, 1, 2'b00, 8'h30, 1, 1, 1, 3'd4, 8'hBB);
    chk("R9 stat wins", mx_out, 2'b00); chk("R9 switch lost 2", emul_flag, 0);
    chk("R9 write lost", dbank, 8'h61);
    cyc(0, 0, 2'b00, 8'h00, 1, 1, 1, 3'd4, 8'hCC);
    chk("R9 switch wins", emul_flag, 1); chk("R9 switch forces mx", mx_out, 2'b11);
    chk("R9 write lost 3", dbank, 8'h61);
  endtask

  initial begin : watchdog
    #100000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_native_writes();
    t_stat_native();
    t_irq_native();
    t_to_emul();
    t_emul_stat();
    t_irq_emul();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule